// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block sits between the write-strobe logic and the page controller of a byte-wide nonvolatile memory. Every completed write cycle arrives as one event: an address and a data byte. The block checks the events against fixed address/data command sequences. A three-write key arms a protection latch and opens one load window. A six-write key clears the latch. While the latch is set, a write reaches the array only inside such a window.

For each event the block drives two outputs in the same cycle. `writeAllow` tells the page controller to load the byte. `blockArray` marks a byte that must not reach the array: a command byte, a write made while programming is busy, or a write that protection refuses. The page controller pulses `pageDone` when a load has been programmed. That pulse closes an open window, so the device locks again. It also completes a pending clear of protection.

The latch stands in for a nonvolatile bit. Its value after reset comes from a parameter.

Top module: `wp_seq_guard`

## Requirements
- R1: The writes 0xAA to address 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, in that order, set the protection latch and open a load window. Data writes made after the third key write have writeAllow=1 until the window closes.
- R2: A one-cycle pageDone pulse closes an open window. After it, with protection set, a plain write gets writeAllow=0 and blockArray=1.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555, in that order, request a clear of protection. Writes stay refused until the next pageDone pulse. After that pulse, plain writes are allowed.
- R4: Address bit 15 takes no part in key matching. For example, 0xD555 matches 0x5555 and 0xAAAA matches 0x2AAA.
- R5: Every write the matcher accepts as a step of a key gets blockArray=1 and writeAllow=0 in the same cycle, whatever the protection state.
- R6: After reset the latch holds the parameter INIT_PROT (default 0: unprotected, so plain writes are allowed). Once set, the latch falls only through a completed clear (R3).
- R7: While protection is set and no window is open, a plain write gets writeAllow=0 and blockArray=1.
- R8: A write that does not match the next expected key step returns the matcher to idle. If that write is itself 0xAA@0x5555, it starts a new key instead. When unprotected, the breaking write is passed as a normal write (writeAllow=1).
- R9: Writes made while progBusy is high leave the matcher unchanged and get writeAllow=0 and blockArray=1. A key interrupted only by such writes still completes.
- R10: With wrValid low, both writeAllow and blockArray are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | One completed write cycle is presented this clock |
| wrAddr | input | 16 | Address of the write |
| wrData | input | 8 | Data byte of the write |
| progBusy | input | 1 | Internal programming cycle in progress |
| pageDone | input | 1 | One-cycle pulse: the current load has been programmed |
| writeAllow | output | 1 | Page controller may load this byte |
| blockArray | output | 1 | This byte must not reach the array |

## Verification
Both qualifiers are combinational in the cycle the event is presented. The bench therefore drives an event at the falling edge and samples writeAllow and blockArray one nanosecond later, before the rising edge. Changes to the latch, the window and the matcher state take effect at that rising edge. The pageDone effect likewise appears from the edge that samples the pulse. Each check of a later state is made on a separate event driven at a following falling edge, so no result is sampled in the cycle where it is still being registered.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_GOT1,
    SEQ_GOT2,
    SEQ_GOT3,
    SEQ_GOT4,
    SEQ_GOT5
  } seqState_t;

  // strobes from the matcher to the protection datapath
  typedef struct packed {
    logic cmdStep;    // this write was consumed as a key step
    logic armFire;    // arm key completed
    logic clearFire;  // clear key completed
  } seqStrobe_t;

endpackage

// File: rtl/wp_seq_ctrl.sv
module wp_seq_ctrl
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA,
  parameter logic [DATA_W-1:0] KEY_LEAD   = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_FOLLOW = 8'h55,
  parameter logic [DATA_W-1:0] KEY_ARM    = 8'hA0,
  parameter logic [DATA_W-1:0] KEY_ERASE  = 8'h80,
  parameter logic [DATA_W-1:0] KEY_CLEAR  = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progBusy,
  output seqStrobe_t        strobe
);

  // top address bit is excluded from key matching
  localparam int CMP_W = ADDR_W - 1;

  seqState_t state, nextState;

  logic take, atA, atB, leadHit, followHit;

  assign take      = wrValid && !progBusy;
  assign atA       = (wrAddr[CMP_W-1:0] == KEY_ADDR_A[CMP_W-1:0]);
  assign atB       = (wrAddr[CMP_W-1:0] == KEY_ADDR_B[CMP_W-1:0]);
  assign leadHit   = atA && (wrData == KEY_LEAD);
  assign followHit = atB && (wrData == KEY_FOLLOW);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (take) begin
      // default on a mismatch: back to idle, or restart on a lead write
      if (leadHit) begin
        nextState      = SEQ_GOT1;
        strobe.cmdStep = 1'b1;
      end else begin
        nextState = SEQ_IDLE;
      end
      unique case (state)
        SEQ_IDLE: ;
        SEQ_GOT1: if (followHit) begin
          nextState      = SEQ_GOT2;
          strobe.cmdStep = 1'b1;
        end
        SEQ_GOT2: if (atA && wrData == KEY_ARM) begin
          nextState      = SEQ_IDLE;
          strobe.cmdStep = 1'b1;
          strobe.armFire = 1'b1;
        end else if (atA && wrData == KEY_ERASE) begin
          nextState      = SEQ_GOT3;
          strobe.cmdStep = 1'b1;
        end
        SEQ_GOT3: if (leadHit) begin
          nextState      = SEQ_GOT4;
          strobe.cmdStep = 1'b1;
        end
        SEQ_GOT4: if (followHit) begin
          nextState      = SEQ_GOT5;
          strobe.cmdStep = 1'b1;
        end
        SEQ_GOT5: if (atA && wrData == KEY_CLEAR) begin
          nextState        = SEQ_IDLE;
          strobe.cmdStep   = 1'b1;
          strobe.clearFire = 1'b1;
        end
        default: nextState = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  // R9: matcher holds while programming is busy
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |=> $stable(state));

  // R8: a non-key write made from a partial match lands in idle
  assert_break_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (take && !strobe.cmdStep) |=> (state == SEQ_IDLE));

endmodule

// File: rtl/wp_seq_path.sv
module wp_seq_path
  import wp_seq_pkg::*;
#(
  parameter bit INIT_PROT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       progBusy,
  input  logic       pageDone,
  input  seqStrobe_t strobe,
  output logic       writeAllow,
  output logic       blockArray
);

  logic protLatch, windowOpen, clearPending;
  logic passOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protLatch    <= INIT_PROT;
      windowOpen   <= 1'b0;
      clearPending <= 1'b0;
    end else if (strobe.armFire) begin
      protLatch    <= 1'b1;
      windowOpen   <= 1'b1;
      clearPending <= 1'b0;
    end else begin
      if (strobe.clearFire) clearPending <= 1'b1;
      if (pageDone) begin
        windowOpen <= 1'b0;
        if (clearPending) begin
          protLatch    <= 1'b0;
          clearPending <= 1'b0;
        end
      end
    end
  end

  assign passOk     = !protLatch || windowOpen;
  assign writeAllow = wrValid && !progBusy && !strobe.cmdStep && passOk;
  assign blockArray = wrValid && !writeAllow;

  assert_arm_open_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armFire |=> (protLatch && windowOpen));

  assert_window_close_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pageDone && !strobe.armFire) |=> !windowOpen);

  assert_clear_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pageDone && clearPending && !strobe.armFire) |=> !protLatch);

  assert_cmd_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmdStep |-> (blockArray && !writeAllow));

  assert_latch_persist_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protLatch) |-> $past(clearPending && pageDone));

  assert_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && protLatch && !windowOpen) |-> !writeAllow);

  assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && progBusy) |-> (blockArray && !writeAllow));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> (!writeAllow && !blockArray));

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter bit INIT_PROT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progBusy,
  input  logic              pageDone,
  output logic              writeAllow,
  output logic              blockArray
);

  seqStrobe_t strobe;

  wp_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .progBusy (progBusy),
    .strobe   (strobe)
  );

  wp_seq_path #(
    .INIT_PROT (INIT_PROT)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .progBusy   (progBusy),
    .pageDone   (pageDone),
    .strobe     (strobe),
    .writeAllow (writeAllow),
    .blockArray (blockArray)
  );

endmodule

// File: tb/wp_seq_guard_bench.sv
module wp_seq_guard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        progBusy = 1'b0;
  logic        pageDone = 1'b0;
  logic        writeAllow, blockArray;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  wp_seq_guard u_wp_seq_guard (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .progBusy   (progBusy),
    .pageDone   (pageDone),
    .writeAllow (writeAllow),
    .blockArray (blockArray)
  );

  task automatic checkOut(input logic expAllow, input logic expBlock, input string tag);
    checks++;
    if (writeAllow !== expAllow || blockArray !== expBlock) begin
      errors++;
      $display("FAIL %s: allow/block actual %b/%b expected %b/%b",
               tag, writeAllow, blockArray, expAllow, expBlock);
    end
  endtask

  // one write event; expAllow=1 means it passes, else it is blocked
  task automatic doWrite(input logic [15:0] a, input logic [7:0] d,
                         input logic expAllow, input string tag);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    #1 checkOut(expAllow, !expAllow, tag);
    @(posedge clk);
    #1 wrValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); pageDone = 1'b1;
    @(posedge clk); #1 pageDone = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1 checkOut(1'b0, 1'b0, "R10 idle outputs");
    doWrite(16'h0010, 8'h11, 1'b1, "R6 unprotected after reset");
  endtask

  task automatic testArm();
    doWrite(16'h5555, 8'hAA, 1'b0, "R5 key step 1");
    doWrite(16'h2AAA, 8'h55, 1'b0, "R5 key step 2");
    doWrite(16'h5555, 8'hA0, 1'b0, "R5 key step 3");
    doWrite(16'h0100, 8'h01, 1'b1, "R1 window byte 0");
    doWrite(16'h0101, 8'h02, 1'b1, "R1 window byte 1");
    pulseDone();
    doWrite(16'h0102, 8'h03, 1'b0, "R2 relocked after load");
    doWrite(16'h0400, 8'h04, 1'b0, "R7 plain write protected");
  endtask

  task automatic testBit15();
    doWrite(16'hD555, 8'hAA, 1'b0, "R4 key step 1 bit15");
    doWrite(16'hAAAA, 8'h55, 1'b0, "R4 key step 2 bit15");
    doWrite(16'hD555, 8'hA0, 1'b0, "R4 key step 3 bit15");
    doWrite(16'h0501, 8'h05, 1'b1, "R4 window via bit15 keys");
    pulseDone();
    doWrite(16'h0502, 8'h06, 1'b0, "R2 relocked again");
  endtask

  task automatic testDisable();
    doWrite(16'h5555, 8'hAA, 1'b0, "R3 clear step 1");
    doWrite(16'h2AAA, 8'h55, 1'b0, "R3 clear step 2");
    doWrite(16'h5555, 8'h80, 1'b0, "R3 clear step 3");
    doWrite(16'h5555, 8'hAA, 1'b0, "R3 clear step 4");
    doWrite(16'h2AAA, 8'h55, 1'b0, "R3 clear step 5");
    doWrite(16'h5555, 8'h20, 1'b0, "R3 clear step 6");
    doWrite(16'h0300, 8'h07, 1'b0, "R3 still locked before done");
    pulseDone();
    doWrite(16'h0300, 8'h08, 1'b1, "R3 unprotected after done");
  endtask

  task automatic testBreak();
    doWrite(16'h5555, 8'hAA, 1'b0, "R8 partial step 1");
    doWrite(16'h2AAA, 8'h55, 1'b0, "R8 partial step 2");
    doWrite(16'h1234, 8'h12, 1'b1, "R8 breaking write passes");
    doWrite(16'h5555, 8'hA0, 1'b1, "R8 stray arm byte is plain");
    pulseDone();
    doWrite(16'h2000, 8'h09, 1'b1, "R8 latch not armed");
    // restart: lead write inside a partial key begins a new key
    doWrite(16'h5555, 8'hAA, 1'b0, "R8 lead 1");
    doWrite(16'h5555, 8'hAA, 1'b0, "R8 lead restarts");
    doWrite(16'h2AAA, 8'h55, 1'b0, "R8 follow after restart");
    doWrite(16'h2001, 8'h0A, 1'b1, "R8 break passes again");
  endtask

  task automatic testBusy();
    @(negedge clk); progBusy = 1'b1;
    doWrite(16'h5555, 8'hAA, 1'b0, "R9 busy write 1");
    doWrite(16'h2AAA, 8'h55, 1'b0, "R9 busy write 2");
    doWrite(16'h5555, 8'hA0, 1'b0, "R9 busy write 3");
    @(negedge clk); progBusy = 1'b0;
    doWrite(16'h0600, 8'h0B, 1'b1, "R9 busy keys ignored");
    doWrite(16'h5555, 8'hAA, 1'b0, "R9 step 1");
    doWrite(16'h2AAA, 8'h55, 1'b0, "R9 step 2");
    @(negedge clk); progBusy = 1'b1;
    doWrite(16'h0000, 8'h12, 1'b0, "R9 busy interloper");
    @(negedge clk); progBusy = 1'b0;
    doWrite(16'h5555, 8'hA0, 1'b0, "R9 step 3 completes key");
    doWrite(16'h0040, 8'h33, 1'b1, "R9 window after held key");
    pulseDone();
    doWrite(16'h0041, 8'h34, 1'b0, "R9 protected after load");
  endtask

  initial begin
    testReset();
    testArm();
    testBit15();
    testDisable();
    testBreak();
    testBusy();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule